// File: doc/BRIEF.md
# Bidirectional Port with Change and Edge Interrupts

An eight-pin general-purpose I/O port. Every pin has its own direction bit, and there is one output latch for the whole port. A single active-low control bit turns the weak pull-ups on, and the hardware forces the pull-up off on any pin that is driving. The pads are modelled as a separate input bus, an output bus and a per-pin output enable. Pad inputs pass through a two-flop synchroniser before any logic uses them.

Two interrupt sources share one request line. The first is a sticky change flag for the upper four pins. Each upper pin that is configured as an input is compared against a snapshot taken at the last port read or port write. Any difference sets the flag, and it keeps setting the flag for as long as the difference remains. The second is an external edge flag on pin 0, with a selectable polarity. Both flags are set whatever their enables hold. The request output is active when a set flag has its enable bit set.

Software reaches the block through a small register port: a two-bit address, read and write strobes, and combinational read data. The registers are data (address 0), direction (address 1) and control (address 2). Control bits are: bit 7 pull-up disable (active low enable), bit 6 edge select (1 = rising, 0 = falling), bit 4 edge interrupt enable, bit 3 change interrupt enable, bit 1 edge flag, bit 0 change flag. Bits 5 and 2 read as 0.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register reads 0xFF, control reads 0xC0, `pin_oe_o` and `pull_en_o` are 0 and `irq_o` is low.
- R2: A direction bit of 0 drives the output latch bit on `pin_o` with its `pin_oe_o` bit high. A direction bit of 1 leaves the pin undriven (`pin_oe_o` bit low).
- R3: A read of address 0 returns the pad states two clocks after they settle. A write to address 0 loads the output latch, which otherwise holds its value.
- R4: A difference between any of pins 7:4 configured as inputs and the snapshot sets control bit 0 by the third clock edge. Changes on pins 3:0 never set it.
- R5: An upper pin configured as an output is excluded from change detection.
- R6: While a difference persists, the change flag sets again after software clears it. A port read or write refreshes the snapshot and ends the difference.
- R7: Both flags set regardless of their enables. `irq_o` is high exactly when (bit0 AND bit3) OR (bit1 AND bit4) of control.
- R8: With control bit 7 = 0, `pull_en_o` is high on every input pin and low on every output pin. With bit 7 = 1, all pull-ups are off.
- R9: With control bit 6 = 1, a rising edge on pin 0 sets control bit 1. With bit 6 = 0, a falling edge sets it and a rising edge does not.
- R10: The flags are sticky. Software writes to control bits 1:0 load them, and a hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 data, 1 direction, 2 control |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a data read refreshes the snapshot) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational on the address |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Output latch towards the pads |
| pin_oe_o | output | 8 | Per-pin output enable |
| pull_en_o | output | 8 | Per-pin weak pull-up enable |
| irq_o | output | 1 | Qualified interrupt request |

## Verification
Change detection is driven with four kinds of pattern. A lower-nibble change shows that only the upper pins are watched. An upper-nibble change on input pins shows that the flag sets even while it is not enabled. A persisting difference shows that clearing the flag alone does not end the condition, and that a port read does. An upper pin switched to output shows that driven pins are excluded. The edge source is exercised with both polarities and both edge directions, which separates edge from level detection and confirms that the select bit is honoured. Pull-up and direction patterns cover mixed input and output nibbles, under both settings of the pull-up control.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  localparam int unsigned CTRL_PU_N   = 7;
  localparam int unsigned CTRL_RISE   = 6;
  localparam int unsigned CTRL_EXT_EN = 4;
  localparam int unsigned CTRL_CHG_EN = 3;
  localparam int unsigned CTRL_EXT_F  = 1;
  localparam int unsigned CTRL_CHG_F  = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned MON_LO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             capture_i,
  output logic             mismatch_o
);
  localparam int unsigned MW = WIDTH - MON_LO;

  logic [MW-1:0] snap_q;
  logic [MW-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= pin_sync_i[WIDTH-1:MON_LO];
  end

  // only input-configured pins take part
  assign diff       = (pin_sync_i[WIDTH-1:MON_LO] ^ snap_q) & dir_i[WIDTH-1:MON_LO];
  assign mismatch_o = |diff;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign hit_o = rise_sel_i ? (pin_i & ~prev_q) : (~pin_i & prev_q);
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned MON_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pull_en_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] out_q, dir_q;
  logic pu_n_q, rise_sel_q, ext_en_q, chg_en_q, chg_flag_q, ext_flag_q;
  logic mismatch, ext_hit;
  logic sel_data, sel_dir, sel_ctrl, wr_data, wr_dir, wr_ctrl, port_touch;

  assign sel_data   = (reg_addr_i == ADDR_DATA);
  assign sel_dir    = (reg_addr_i == ADDR_DIR);
  assign sel_ctrl   = (reg_addr_i == ADDR_CTRL);
  assign wr_data    = reg_wr_i & sel_data;
  assign wr_dir     = reg_wr_i & sel_dir;
  assign wr_ctrl    = reg_wr_i & sel_ctrl;
  assign port_touch = (reg_wr_i | reg_rd_i) & sel_data;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_ioc_detect #(.WIDTH(WIDTH), .MON_LO(MON_LO)) u_ioc (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_sync_i(pin_sync), .dir_i(dir_q),
    .capture_i(port_touch), .mismatch_o(mismatch)
  );

  gpio_edge_detect u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_sync[0]),
    .rise_sel_i(rise_sel_q), .hit_o(ext_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr_data) out_q <= reg_wdata_i[WIDTH-1:0];
      if (wr_dir)  dir_q <= reg_wdata_i[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_n_q     <= 1'b1;
      rise_sel_q <= 1'b1;
      ext_en_q   <= 1'b0;
      chg_en_q   <= 1'b0;
    end else if (wr_ctrl) begin
      pu_n_q     <= reg_wdata_i[CTRL_PU_N];
      rise_sel_q <= reg_wdata_i[CTRL_RISE];
      ext_en_q   <= reg_wdata_i[CTRL_EXT_EN];
      chg_en_q   <= reg_wdata_i[CTRL_CHG_EN];
    end
  end

  // hardware set outranks a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_flag_q <= 1'b0;
      ext_flag_q <= 1'b0;
    end else begin
      if (mismatch)     chg_flag_q <= 1'b1;
      else if (wr_ctrl) chg_flag_q <= reg_wdata_i[CTRL_CHG_F];
      if (ext_hit)      ext_flag_q <= 1'b1;
      else if (wr_ctrl) ext_flag_q <= reg_wdata_i[CTRL_EXT_F];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (1'b1)
      sel_data: reg_rdata_o[WIDTH-1:0] = pin_sync;
      sel_dir:  reg_rdata_o[WIDTH-1:0] = dir_q;
      sel_ctrl: begin
        reg_rdata_o[CTRL_PU_N]   = pu_n_q;
        reg_rdata_o[CTRL_RISE]   = rise_sel_q;
        reg_rdata_o[CTRL_EXT_EN] = ext_en_q;
        reg_rdata_o[CTRL_CHG_EN] = chg_en_q;
        reg_rdata_o[CTRL_EXT_F]  = ext_flag_q;
        reg_rdata_o[CTRL_CHG_F]  = chg_flag_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign pin_o     = out_q;
  assign pin_oe_o  = ~dir_q;
  assign pull_en_o = dir_q & {WIDTH{~pu_n_q}};
  assign irq_o     = (chg_flag_q & chg_en_q) | (ext_flag_q & ext_en_q);
endmodule

// File: rtl/gpio_ioc_port_chk.sv
module gpio_ioc_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       reg_addr_i,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] pull_en_o,
  input logic             irq_o,
  input logic [WIDTH-1:0] pin_sync,
  input logic             mismatch,
  input logic             rise_sel_q,
  input logic             chg_flag_q,
  input logic             ext_flag_q
);
  logic ctrl_wr, data_wr, data_touch;
  assign ctrl_wr    = reg_wr_i && reg_addr_i == 2'd2;
  assign data_wr    = reg_wr_i && reg_addr_i == 2'd0;
  assign data_touch = (reg_wr_i || reg_rd_i) && reg_addr_i == 2'd0;

  assert_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr |=> $stable(pin_o));

  assert_change_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch |=> chg_flag_q);

  assert_touch_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_touch && $stable(pin_sync)) |=> (!mismatch || !$stable(pin_sync)));

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_flag_q && !ext_flag_q) |-> !irq_o);

  assert_pull_off_driven_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & pull_en_o) == '0);

  assert_rise_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pin_sync[0]) && rise_sel_q) |=> ext_flag_q);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_flag_q && !ctrl_wr) |=> chg_flag_q);
endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_rd_i(reg_rd_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .pull_en_o(pull_en_o),
  .irq_o(irq_o), .pin_sync(pin_sync), .mismatch(mismatch), .rise_sel_q(rise_sel_q),
  .chg_flag_q(chg_flag_q), .ext_flag_q(ext_flag_q)
);

// File: tb/gpio_ioc_port_test.sv
`timescale 1ns/1ps
module gpio_ioc_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pins = '0;
  logic [7:0] pout, poe, pull;
  logic       irq;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_ioc_port uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .pull_en_o(pull), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    wait_cyc(1);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    wait_cyc(1);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_read(2'd1, v); check("R1 dir reset", v, 8'hFF);
    do_read(2'd2, v); check("R1 ctrl reset", v, 8'hC0);
    check("R1 oe reset", poe, 8'h00);
    check("R1 pull reset", pull, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_direction();
    do_write(2'd1, 8'hF0);
    do_write(2'd0, 8'hA5);
    check("R2 oe mixed", poe, 8'h0F);
    check("R3 latch write", pout, 8'hA5);
    do_write(2'd1, 8'hFF);
    check("R2 oe all input", poe, 8'h00);
    check("R3 latch hold", pout, 8'hA5);
  endtask

  task automatic t_read_and_low_nibble();
    logic [7:0] v;
    pins = 8'h3C;
    wait_cyc(2);
    do_read(2'd0, v); check("R3 pin read", v, 8'h3C);
    do_write(2'd2, 8'hC0);
    wait_cyc(2);
    do_read(2'd2, v); check("R6 cleared after resync", v, 8'hC0);
    pins = 8'h38;
    wait_cyc(5);
    do_read(2'd2, v); check("R4 low nibble ignored", v, 8'hC0);
  endtask

  task automatic t_change();
    logic [7:0] v;
    pins = 8'h78;
    wait_cyc(4);
    do_read(2'd2, v); check("R7 flag without enable", v, 8'hC1);
    check("R7 irq masked", {7'b0, irq}, 8'h00);
    do_write(2'd2, 8'hC9);
    check("R7 irq enabled", {7'b0, irq}, 8'h01);
    do_write(2'd2, 8'hC8);
    wait_cyc(2);
    do_read(2'd2, v); check("R6 flag resets while mismatch", v, 8'hC9);
    do_read(2'd0, v); check("R3 pin read upper", v, 8'h78);
    do_write(2'd2, 8'hC8);
    wait_cyc(3);
    do_read(2'd2, v); check("R6 read ends mismatch", v, 8'hC8);
    check("R7 irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_output_excluded();
    logic [7:0] v;
    do_write(2'd1, 8'h7F);
    pins = 8'hF8;
    wait_cyc(4);
    do_read(2'd2, v); check("R5 output pin excluded", v, 8'hC8);
    do_write(2'd1, 8'hFF);
    wait_cyc(2);
    do_read(2'd2, v); check("R4 pin back to input differs", v, 8'hC9);
    do_write(2'd0, 8'h00);
    do_write(2'd2, 8'hC0);
    wait_cyc(3);
    do_read(2'd2, v); check("R6 write ends mismatch", v, 8'hC0);
  endtask

  task automatic t_pullup();
    check("R8 pulls off", pull, 8'h00);
    do_write(2'd2, 8'h40);
    check("R8 pulls all inputs", pull, 8'hFF);
    do_write(2'd1, 8'h0F);
    check("R8 pulls off on outputs", pull, 8'h0F);
    do_write(2'd1, 8'hFF);
    do_write(2'd2, 8'hC0);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    do_write(2'd2, 8'hD0);
    pins = 8'hF9;
    wait_cyc(4);
    do_read(2'd2, v); check("R9 rising edge", v, 8'hD2);
    check("R7 irq edge", {7'b0, irq}, 8'h01);
    do_write(2'd2, 8'h90);
    pins = 8'hF8;
    wait_cyc(4);
    do_read(2'd2, v); check("R9 falling edge", v, 8'h92);
    do_write(2'd2, 8'h90);
    pins = 8'hF9;
    wait_cyc(4);
    do_read(2'd2, v); check("R9 rise ignored in falling mode", v, 8'h90);
    check("R9 irq stays low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_sw_flags();
    logic [7:0] v;
    do_write(2'd2, 8'h83);
    wait_cyc(3);
    do_read(2'd2, v); check("R10 software sets flags", v, 8'h83);
    do_write(2'd2, 8'h80);
    do_read(2'd2, v); check("R10 software clears flags", v, 8'h80);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_direction();
    t_read_and_low_nibble();
    t_change();
    t_output_excluded();
    t_pullup();
    t_edge();
    t_sw_flags();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule